// File: doc/BRIEF.md
# Clock Lane High-Speed Entry and Exit Sequencer

This block decides, cycle by cycle on the byte clock, when the clock lane and the data lanes of a display serial link leave low-power mode for high speed and when they return to it. A burst starts when the host raises its transmit request. The clock lane goes to high speed first. After a programmable lead time the data lanes follow, and they stay in high speed while the request is held. When the request drops, the block can have end-of-transmission short packets appended while the data lanes are still in high speed. It then releases the data lanes, waits for the physical layer to report stop state, keeps the clock running for a programmable trailing time, and parks the clock lane in low power for a programmable minimum rest period.

In free-running clock mode, the clock lane stays in high speed once it has started. Only the data lanes switch between high speed and stop state, and a new burst needs no lead time. A transmit request that arrives while the sequence is winding down is latched, so the burst starts as soon as the rules allow. Packet assembly and analog signalling are handled elsewhere. The block only issues the end-of-transmission insert strobes and takes an acknowledge for each one.

Top module: `hs_clk_lane_seq`

## Requirements
- R1: While reset is held and after reset until the first request, `clk_hs_en`, `data_hs_en` and `eot_stb` are all 0.
- R2: `clk_hs_en` rises on the first clock edge that samples `tx_req` high in the rest state. `data_hs_en` stays 0 at that edge and becomes nonzero exactly P edges later, where P is `cfg_pre`.
- R3: The data lanes stay in high speed while `tx_req` is held. Without end-of-transmission insertion, `data_hs_en` returns to 0 on the first edge that samples `tx_req` low, and `clk_hs_en` stays 1.
- R4: With `cfg_clk_gated`=1, the clock lane stays in high speed while `dl_stop` is 0 after the data lanes are released. It drops exactly Q edges after the first edge that samples `dl_stop`=1, where Q is `cfg_post`.
- R5: After `clk_hs_en` falls, it cannot rise again for G edges, where G is `cfg_gap`. If a request is waiting, it rises exactly G edges after the fall.
- R6: A programmed value of 0 in `cfg_pre`, `cfg_post` or `cfg_gap` behaves as 1, so every phase lasts at least one byte clock.
- R7: With `cfg_clk_gated`=0, the clock lane stays in high speed after a burst ends. The next request turns the data lanes on at the very next edge, with no lead time. Changing `cfg_clk_gated` to 1 while idle in this state starts the trailing time Q and then turns the clock lane off.
- R8: With `cfg_eot_auto`=1, the edge that samples `tx_req` low raises `eot_stb` for one cycle. The block issues 1 + `cfg_eot_extra` strobes in total. Each later strobe follows the edge that samples `eot_ack`=1 after the previous strobe, and the data lanes stay in high speed until the last acknowledge. With `cfg_eot_auto`=0, no strobe is issued and `cfg_eot_extra` has no effect.
- R9: `cfg_lane_sel` picks the active data lanes: 00 enables only bit 0 of `data_hs_en`, and 01 enables bits 0 and 1. Larger codes enable every lane present.
- R10: A `tx_req` pulse that arrives during the trailing time or the rest period is kept. It produces a full burst once the rest period ends, even if `tx_req` has already dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_req | input | 1 | Host transmit request, held for the length of the burst |
| dl_stop | input | 1 | Data lanes report stop state |
| cfg_clk_gated | input | 1 | 1: clock lane rests in low power between bursts; 0: free-running clock |
| cfg_eot_auto | input | 1 | 1: append end-of-transmission packets at burst end |
| cfg_eot_extra | input | EOT_CNT_W | Number of additional end-of-transmission packets |
| cfg_lane_sel | input | LANE_SEL_W | Active data lane code |
| cfg_pre | input | DLY_W | Clock-to-data lead time in byte clocks |
| cfg_post | input | DLY_W | Stop-state-to-clock-off trailing time in byte clocks |
| cfg_gap | input | DLY_W | Minimum clock lane rest time in byte clocks |
| eot_ack | input | 1 | Packet path accepted the current end-of-transmission packet |
| clk_hs_en | output | 1 | Clock lane high-speed enable |
| data_hs_en | output | LANE_CNT | Per-lane data high-speed enable |
| eot_stb | output | 1 | One-cycle request to insert one end-of-transmission packet |

## Verification
A phase timer loaded with the wrong count, or released one cycle off, moves the edge of `clk_hs_en` or `data_hs_en` by exactly that error. Counting edges from the triggering edge exposes it within the phase itself. A state machine that skips the drain or trailing phase turns the clock off while the data lanes are still active or were active one cycle earlier, which is visible on the very next edge. A lost pending request or a miscounted packet counter shows as a burst that never arrives or a strobe too many or too few, within a few cycles of the expected acknowledge.

// File: rtl/hs_seq_pkg.sv
package hs_seq_pkg;
   typedef enum logic [3:0] {
      ST_REST,      // clock lane low power, idle
      ST_LEAD,      // clock lane HS, data lanes still LP
      ST_BURST,     // both in HS, payload flowing
      ST_EOT_ISS,   // strobe one end-of-transmission packet
      ST_EOT_WAIT,  // wait for the packet path to accept it
      ST_DRAIN,     // data lanes released, waiting for stop state
      ST_TRAIL,     // clock still HS after stop state
      ST_GAP,       // clock lane LP, minimum rest
      ST_CLK_ON     // free-running clock, data lanes LP
   } seq_st_e;
endpackage

// File: rtl/hs_phase_timer.sv
module hs_phase_timer #(
   parameter int DLY_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [DLY_W-1:0] load_val,
   output logic             last
);
   localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

   logic [DLY_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= (load_val == '0) ? ONE : load_val;
      else if (cnt_q > ONE)
         cnt_q <= cnt_q - ONE;
   end

   assign last = (cnt_q == ONE);
endmodule

// File: rtl/hs_lane_mask.sv
module hs_lane_mask #(
   parameter int LANE_CNT   = 2,
   parameter int LANE_SEL_W = 2
) (
   input  logic [LANE_SEL_W-1:0] sel,
   output logic [LANE_CNT-1:0]   mask
);
   localparam int CMP_W = LANE_SEL_W + 8;

   for (genvar i = 0; i < LANE_CNT; i++) begin : g_lane
      assign mask[i] = (CMP_W'(sel) >= CMP_W'(i));
   end
endmodule

// File: rtl/hs_clk_lane_seq.sv
module hs_clk_lane_seq
   import hs_seq_pkg::*;
#(
   parameter int DLY_W      = 8,
   parameter int EOT_CNT_W  = 8,
   parameter int LANE_CNT   = 2,
   parameter int LANE_SEL_W = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  tx_req,
   input  logic                  dl_stop,
   input  logic                  cfg_clk_gated,
   input  logic                  cfg_eot_auto,
   input  logic [EOT_CNT_W-1:0]  cfg_eot_extra,
   input  logic [LANE_SEL_W-1:0] cfg_lane_sel,
   input  logic [DLY_W-1:0]      cfg_pre,
   input  logic [DLY_W-1:0]      cfg_post,
   input  logic [DLY_W-1:0]      cfg_gap,
   input  logic                  eot_ack,
   output logic                  clk_hs_en,
   output logic [LANE_CNT-1:0]   data_hs_en,
   output logic                  eot_stb
);
   localparam int MAX_LANES = 1 << LANE_SEL_W;

   if (LANE_CNT < 1 || LANE_CNT > MAX_LANES) begin : g_bad_lanes
      $error("LANE_CNT must lie between 1 and 2**LANE_SEL_W");
   end
   if (DLY_W < 1 || EOT_CNT_W < 1) begin : g_bad_widths
      $error("delay and packet count widths must be at least 1");
   end

   seq_st_e st_q, st_d;
   logic    pend_q;
   logic    go;
   logic    tmr_load, tmr_last;
   logic [DLY_W-1:0]     tmr_val;
   logic [EOT_CNT_W-1:0] eot_left_q;
   logic [LANE_CNT-1:0]  lane_mask;
   logic                 clk_on, data_on;

   assign go = tx_req | pend_q;

   // next-state selection
   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_REST:     if (go) st_d = ST_LEAD;
         ST_LEAD:     if (tmr_last) st_d = ST_BURST;
         ST_BURST:    if (!tx_req) st_d = cfg_eot_auto ? ST_EOT_ISS : ST_DRAIN;
         ST_EOT_ISS:  st_d = ST_EOT_WAIT;
         ST_EOT_WAIT: if (eot_ack) st_d = (eot_left_q == '0) ? ST_DRAIN : ST_EOT_ISS;
         ST_DRAIN:    if (dl_stop) st_d = cfg_clk_gated ? ST_TRAIL : ST_CLK_ON;
         ST_TRAIL:    if (tmr_last) st_d = ST_GAP;
         ST_GAP:      if (tmr_last) st_d = go ? ST_LEAD : ST_REST;
         ST_CLK_ON: begin
            if (cfg_clk_gated) st_d = ST_TRAIL;
            else if (go)       st_d = ST_BURST;
         end
         default:     st_d = ST_REST;
      endcase
   end

   // phase timer is loaded on entry to a timed phase
   always_comb begin
      tmr_load = 1'b0;
      tmr_val  = cfg_pre;
      if (st_d != st_q) begin
         unique case (st_d)
            ST_LEAD:  begin tmr_load = 1'b1; tmr_val = cfg_pre;  end
            ST_TRAIL: begin tmr_load = 1'b1; tmr_val = cfg_post; end
            ST_GAP:   begin tmr_load = 1'b1; tmr_val = cfg_gap;  end
            default:  ;
         endcase
      end
   end

   hs_phase_timer #(.DLY_W(DLY_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .last     (tmr_last)
   );

   hs_lane_mask #(.LANE_CNT(LANE_CNT), .LANE_SEL_W(LANE_SEL_W)) u_mask (
      .sel  (cfg_lane_sel),
      .mask (lane_mask)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_REST;
         pend_q     <= 1'b0;
         eot_left_q <= '0;
      end else begin
         st_q <= st_d;
         // requests seen while winding down are kept until serviced
         if (st_q == ST_LEAD || st_q == ST_BURST)
            pend_q <= 1'b0;
         else if (tx_req && st_q != ST_REST && st_q != ST_CLK_ON)
            pend_q <= 1'b1;
         if (st_q == ST_BURST && st_d == ST_EOT_ISS)
            eot_left_q <= cfg_eot_extra;
         else if (st_q == ST_EOT_WAIT && eot_ack && eot_left_q != '0)
            eot_left_q <= eot_left_q - 1'b1;
      end
   end

   always_comb begin
      clk_on  = 1'b0;
      data_on = 1'b0;
      eot_stb = 1'b0;
      unique case (st_q)
         ST_LEAD, ST_DRAIN, ST_TRAIL, ST_CLK_ON: clk_on = 1'b1;
         ST_BURST, ST_EOT_WAIT: begin clk_on = 1'b1; data_on = 1'b1; end
         ST_EOT_ISS: begin clk_on = 1'b1; data_on = 1'b1; eot_stb = 1'b1; end
         default: ;
      endcase
   end

   assign clk_hs_en  = clk_on;
   assign data_hs_en = data_on ? lane_mask : '0;
endmodule

// File: rtl/hs_clk_lane_seq_chk.sv
module hs_clk_lane_seq_chk #(
   parameter int DLY_W    = 8,
   parameter int LANE_CNT = 2
) (
   input logic                clk,
   input logic                rst_n,
   input logic                clk_hs_en,
   input logic [LANE_CNT-1:0] data_hs_en,
   input logic                eot_stb,
   input logic [DLY_W-1:0]    cfg_gap
);
   localparam logic [DLY_W:0] SAT = {1'b1, {DLY_W{1'b0}}};

   logic [DLY_W:0] lp_cnt;
   logic [DLY_W:0] gap_eff;

   assign gap_eff = (cfg_gap == '0) ? (DLY_W+1)'(1) : {1'b0, cfg_gap};

   // cycles the clock lane has spent in low power since it last fell
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          lp_cnt <= SAT;
      else if (clk_hs_en)  lp_cnt <= '0;
      else if (lp_cnt != SAT) lp_cnt <= lp_cnt + 1'b1;
   end

   p_data_under_clk_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (data_hs_en != '0) |-> clk_hs_en);

   p_clk_leads_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clk_hs_en) |-> (data_hs_en == '0));

   p_clk_off_after_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(clk_hs_en) |-> (data_hs_en == '0) && ($past(data_hs_en) == '0));

   p_gap_respected_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clk_hs_en) |-> (lp_cnt >= gap_eff));

   p_eot_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      eot_stb |=> !eot_stb);

   p_eot_in_hs_r8: assert property (@(posedge clk) disable iff (!rst_n)
      eot_stb |-> (data_hs_en != '0));

   p_lane0_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (data_hs_en != '0) |-> data_hs_en[0]);
endmodule

bind hs_clk_lane_seq hs_clk_lane_seq_chk #(.DLY_W(DLY_W), .LANE_CNT(LANE_CNT)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .clk_hs_en  (clk_hs_en),
   .data_hs_en (data_hs_en),
   .eot_stb    (eot_stb),
   .cfg_gap    (cfg_gap)
);

// File: tb/tb_hs_clk_lane_seq.sv
`timescale 1ns/1ps
module tb_hs_clk_lane_seq;
   localparam int DLY_W = 8, EOT_CNT_W = 8, LANE_CNT = 2, LANE_SEL_W = 2;

   logic clk = 1'b0, rst_n = 1'b0;
   logic tx_req = 0, dl_stop = 1, cfg_clk_gated = 1, cfg_eot_auto = 0, eot_ack = 0;
   logic [EOT_CNT_W-1:0]  cfg_eot_extra = '0;
   logic [LANE_SEL_W-1:0] cfg_lane_sel = '0;
   logic [DLY_W-1:0]      cfg_pre = 8'd1, cfg_post = 8'd1, cfg_gap = 8'd1;
   logic                  clk_hs_en, eot_stb;
   logic [LANE_CNT-1:0]   data_hs_en;
   int nchk = 0, nerr = 0;

   always #2.5 clk = ~clk;

   hs_clk_lane_seq #(.DLY_W(DLY_W), .EOT_CNT_W(EOT_CNT_W), .LANE_CNT(LANE_CNT),
                     .LANE_SEL_W(LANE_SEL_W)) dut (
      .clk(clk), .rst_n(rst_n), .tx_req(tx_req), .dl_stop(dl_stop),
      .cfg_clk_gated(cfg_clk_gated), .cfg_eot_auto(cfg_eot_auto),
      .cfg_eot_extra(cfg_eot_extra), .cfg_lane_sel(cfg_lane_sel),
      .cfg_pre(cfg_pre), .cfg_post(cfg_post), .cfg_gap(cfg_gap),
      .eot_ack(eot_ack), .clk_hs_en(clk_hs_en), .data_hs_en(data_hs_en),
      .eot_stb(eot_stb));

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic wait_clk(input logic v, output int n);
      n = 0;
      while (clk_hs_en !== v && n < 600) begin step(); n++; end
   endtask

   task automatic wait_data(output int n);
      n = 0;
      while (data_hs_en == '0 && n < 600) begin step(); n++; end
   endtask

   task automatic settle();
      int n;
      wait_clk(1'b0, n);
      repeat (20) step();
   endtask

   task automatic t_reset();
      chk(clk_hs_en == 0 && data_hs_en == 0 && eot_stb == 0, "R1 in reset",
          {clk_hs_en, data_hs_en, eot_stb}, 0);
      rst_n = 1'b1;
      repeat (5) step();
      chk(clk_hs_en == 0 && data_hs_en == 0 && eot_stb == 0, "R1 after reset",
          {clk_hs_en, data_hs_en, eot_stb}, 0);
   endtask

   task automatic t_gated();
      int n, m;
      cfg_clk_gated = 1; cfg_eot_auto = 0; cfg_lane_sel = 2'b01;
      cfg_pre = 8'd3; cfg_post = 8'd4; cfg_gap = 8'd5; dl_stop = 0;
      tx_req = 1; step();
      chk(clk_hs_en == 1 && data_hs_en == 0, "R2 clock first", {clk_hs_en, data_hs_en}, 4);
      wait_data(n);
      chk(n == 3, "R2 lead time", n, 3);
      chk(data_hs_en == 2'b11, "R9 two lanes", data_hs_en, 3);
      step(); step();
      chk(data_hs_en == 2'b11, "R3 held burst", data_hs_en, 3);
      tx_req = 0; step();
      chk(data_hs_en == 0 && clk_hs_en == 1, "R3 data release", {clk_hs_en, data_hs_en}, 4);
      repeat (3) step();
      chk(clk_hs_en == 1, "R4 waits stop state", clk_hs_en, 1);
      dl_stop = 1; step();
      wait_clk(1'b0, n);
      chk(n == 4, "R4 trailing time", n, 4);
      tx_req = 1; step(); tx_req = 0;
      wait_clk(1'b1, m);
      chk(n >= 0 && m + 1 == 5, "R5 rest period", m + 1, 5);
      wait_data(n);
      chk(n == 3, "R10 pending burst served", n, 3);
      settle();
   endtask

   task automatic t_zero();
      int n;
      cfg_clk_gated = 1; cfg_lane_sel = 2'b00;
      cfg_pre = 0; cfg_post = 0; cfg_gap = 0; dl_stop = 1;
      tx_req = 1; step();
      wait_data(n);
      chk(n == 1, "R6 zero lead", n, 1);
      chk(data_hs_en == 2'b01, "R9 one lane", data_hs_en, 1);
      tx_req = 0; step(); step();
      wait_clk(1'b0, n);
      chk(n == 1, "R6 zero trailing", n, 1);
      tx_req = 1;
      wait_clk(1'b1, n);
      chk(n == 1, "R6 zero rest", n, 1);
      tx_req = 0;
      settle();
   endtask

   task automatic t_free_clock();
      int n, drops;
      cfg_clk_gated = 0; cfg_lane_sel = 2'b01;
      cfg_pre = 2; cfg_post = 2; cfg_gap = 2; dl_stop = 1;
      tx_req = 1; step();
      wait_data(n);
      chk(n == 2, "R7 first lead", n, 2);
      tx_req = 0; step();
      chk(data_hs_en == 0, "R7 data release", data_hs_en, 0);
      drops = 0;
      for (int i = 0; i < 10; i++) begin step(); if (!clk_hs_en) drops++; end
      chk(drops == 0, "R7 clock kept", drops, 0);
      tx_req = 1; step();
      chk(data_hs_en == 2'b11, "R7 no lead", data_hs_en, 3);
      tx_req = 0; step(); repeat (3) step();
      cfg_clk_gated = 1; step();
      wait_clk(1'b0, n);
      chk(n == 2, "R7 switch to gated", n, 2);
      settle();
   endtask

   task automatic t_eot();
      int n, strobes;
      cfg_clk_gated = 1; cfg_eot_auto = 1; cfg_eot_extra = 2; cfg_lane_sel = 2'b00;
      cfg_pre = 1; cfg_post = 1; cfg_gap = 1; dl_stop = 1; eot_ack = 0;
      tx_req = 1; step(); wait_data(n); step();
      tx_req = 0; step();
      chk(eot_stb == 1 && data_hs_en == 2'b01, "R8 first strobe", {eot_stb, data_hs_en}, 5);
      strobes = 1;
      step();
      chk(eot_stb == 0, "R8 one-cycle strobe", eot_stb, 0);
      n = 0;
      for (int i = 0; i < 3; i++) begin step(); if (eot_stb || data_hs_en == 0) n++; end
      chk(n == 0, "R8 waits for ack", n, 0);
      for (int k = 0; k < 2; k++) begin
         eot_ack = 1; step(); eot_ack = 0;
         if (eot_stb) strobes++;
         step();
         chk(eot_stb == 0, "R8 strobe pulse", eot_stb, 0);
      end
      eot_ack = 1; step(); eot_ack = 0;
      chk(strobes == 3, "R8 strobe count", strobes, 3);
      chk(data_hs_en == 0 && eot_stb == 0, "R8 release after last ack",
          {eot_stb, data_hs_en}, 0);
      settle();
      cfg_eot_auto = 0; cfg_eot_extra = 5;
      tx_req = 1; step(); wait_data(n); step();
      tx_req = 0; step();
      chk(data_hs_en == 0 && eot_stb == 0, "R8 insertion off", {eot_stb, data_hs_en}, 0);
      n = 0;
      for (int i = 0; i < 10; i++) begin step(); if (eot_stb) n++; end
      chk(n == 0, "R8 extra count ignored", n, 0);
      settle();
   endtask

   initial begin
      repeat (3) step();
      t_reset();
      t_gated();
      t_zero();
      t_free_clock();
      t_eot();
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin
      #(200000 * 5);
      nchk++; nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end
endmodule